// File: doc/BRIEF.md
# Serial Sample Input Port Controller

This block is the clock-master end of a one-wire serial link over which a host supplies transmit samples. From the system clock it derives a bit clock at a programmable ratio. For each accepted sample request it sends a frame-sync pulse. It then clocks in zero, one or two 16-bit channel words on a single data input and presents each captured word on a parallel output with a one-cycle strobe.

Software programs two byte-wide settings through a small write port. Address 0 holds the divide ratio. Address 1 holds the channel selects, the port enable and the clock polarity. The per-sample request strobe and two transmit-channel enable inputs come from the surrounding datapath.

The parallel outputs form a valid-only stream with no ready. The consumer must take each word in the cycle its strobe is high, because the port cannot stall a host that is already clocking. A word stays on its output until the next strobe for that channel replaces it.

Top module: `srp_port`

## Requirements
- R1: With divide value D written at address 0, the bit clock period is D system clocks for D = 2..255; D = 0 gives 256 and D = 1 gives 2.
- R2: The uninverted bit clock is high for ceil(P/2) system clocks and low for floor(P/2), where P is the period, so an odd period has the longer half high.
- R3: After reset both settings are zero: the port is disabled, the period is 256, and bit clock, frame sync and both strobes are low.
- R4: At address 1, bit 2 includes channel A and bit 3 includes channel B in each frame. An excluded channel has no bits in the frame, gets no strobe, and its output word is unchanged.
- R5: Setting address 1 bit 1 starts the bit clock with a high phase. When it is cleared with no frame in progress, the clock stops at the end of the current bit period and then stays low.
- R6: Clearing the enable during a frame lets that frame finish and deliver its words before the clock stops.
- R7: A frame starts only if the port is enabled and at least one channel-enable input is high. A request made while this does not hold is dropped.
- R8: Address 1 bit 0 inverts the bit clock pin. The bit is taken only when the port is disabled and the clock is stopped; writes at any other time leave the polarity unchanged.
- R9: Bits 7..4 at address 1 are ignored.
- R10: Frame sync is high for exactly one bit period, which starts on an uninverted rising edge. The data bits follow, most significant bit first, channel A before channel B. The port samples data on the uninverted falling edge; the host changes data on the rising edge.
- R11: After the last bit period of a frame, the captured words are loaded and each included channel's strobe is high for exactly one system clock.
- R12: One request that arrives during a frame is held. The next sync then follows the last data bit directly, so sync rises are (1+16n)·P system clocks apart for n included channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 1 | 0 = divide ratio, 1 = control |
| cfg_wdata | input | 8 | Write data |
| sample_req | input | 1 | One-cycle request for one frame |
| chan_en_a | input | 1 | Transmit channel A enabled |
| chan_en_b | input | 1 | Transmit channel B enabled |
| bclk_o | output | 1 | Bit clock pin |
| fsync_o | output | 1 | Frame sync pin |
| sdata_i | input | 1 | Serial data pin |
| word_a_data | output | 16 | Channel A captured word |
| word_a_valid | output | 1 | Channel A strobe |
| word_b_data | output | 16 | Channel B captured word |
| word_b_valid | output | 1 | Channel B strobe |

## Verification
The bench measures the phase lengths at the odd, even, zero and one divide settings. A divider that miscounts, or that does not map zero to 256, shows up as wrong high or low lengths. It clears the enable in the middle of a frame; a port that stops at once loses the strobes or leaves the clock running. It also tries to flip the polarity while the clock is running, which a port without the freeze would obey. Back-to-back requests expose any idle bit inserted between frames. Single-channel and reserved-bit frames catch a shift register that is not bypassed, which would corrupt the word or raise a stray strobe.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA
  } frame_st_e;

  typedef struct packed {
    logic sel_b;
    logic sel_a;
    logic en;
    logic inv;
  } port_ctrl_t;
endpackage

// File: rtl/srp_cfg.sv
module srp_cfg
  import srp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             addr,
  input  logic [7:0]       wdata,
  input  logic             running,
  output logic [DIV_W-1:0] div_q,
  output port_ctrl_t       ctrl_q
);
  // polarity may only move while the clock is fully stopped
  logic inv_open;
  assign inv_open = !running && !ctrl_q.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ctrl_q <= '0;
    end else if (we) begin
      if (!addr) begin
        div_q <= wdata[DIV_W-1:0];
      end else begin
        ctrl_q.sel_b <= wdata[3];
        ctrl_q.sel_a <= wdata[2];
        ctrl_q.en    <= wdata[1];
        if (inv_open) ctrl_q.inv <= wdata[0];
      end
    end
  end
endmodule

// File: rtl/srp_bitclk.sv
module srp_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             raw_o,
  output logic             fall_tick_o,
  output logic             bit_last_o
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] period, hi_len, cnt;

  always_comb begin
    if (div == '0)      period = {1'b1, {DIV_W{1'b0}}};
    else if (div == 1)  period = CW'(2);
    else                period = {1'b0, div};
    hi_len = (period + CW'(1)) >> 1;
  end

  assign bit_last_o  = run && (cnt >= period - CW'(1));
  assign fall_tick_o = run && (cnt == hi_len - CW'(1));
  assign raw_o       = run && (cnt < hi_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!run || bit_last_o) cnt <= '0;
    else                         cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/srp_frame.sv
module srp_frame
  import srp_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_last,
  input  logic              fall_tick,
  input  logic              start_ok,
  input  logic              sel_a,
  input  logic              sel_b,
  input  logic              sdata_i,
  output logic              fsync_o,
  output logic              cont_o,
  output logic              take_o,
  output logic [WORD_W-1:0] word_a_o,
  output logic              word_a_valid_o,
  output logic [WORD_W-1:0] word_b_o,
  output logic              word_b_valid_o
);
  localparam int CW = $clog2(2 * WORD_W + 1);
  localparam logic [CW-1:0] WL = CW'(WORD_W);

  frame_st_e         st;
  logic [CW-1:0]     bitn, nbits;
  logic              fsa, fsb;
  logic [WORD_W-1:0] sr_a, sr_b;
  logic              last_data, done, in_a;

  assign last_data = (st == ST_DATA) && (bitn == nbits - CW'(1));
  assign done      = bit_last && (last_data || (st == ST_SYNC && nbits == '0));
  assign cont_o    = (st == ST_SYNC && nbits != '0) || (st == ST_DATA && !last_data);
  assign take_o    = bit_last && start_ok && !cont_o;
  assign fsync_o   = (st == ST_SYNC);
  assign in_a      = fsa && (bitn < WL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= ST_IDLE;
      bitn           <= '0;
      nbits          <= '0;
      fsa            <= 1'b0;
      fsb            <= 1'b0;
      sr_a           <= '0;
      sr_b           <= '0;
      word_a_o       <= '0;
      word_b_o       <= '0;
      word_a_valid_o <= 1'b0;
      word_b_valid_o <= 1'b0;
    end else begin
      word_a_valid_o <= 1'b0;
      word_b_valid_o <= 1'b0;
      if (take_o) begin
        st    <= ST_SYNC;
        fsa   <= sel_a;
        fsb   <= sel_b;
        nbits <= (sel_a ? WL : '0) + (sel_b ? WL : '0);
      end else if (bit_last) begin
        if (st == ST_SYNC && nbits != '0) begin
          st   <= ST_DATA;
          bitn <= '0;
        end else if (st == ST_DATA && !last_data) begin
          bitn <= bitn + CW'(1);
        end else begin
          st <= ST_IDLE;
        end
      end
      if (done) begin
        if (fsa) begin
          word_a_o       <= sr_a;
          word_a_valid_o <= 1'b1;
        end
        if (fsb) begin
          word_b_o       <= sr_b;
          word_b_valid_o <= 1'b1;
        end
      end
      if (fall_tick && st == ST_DATA) begin
        if (in_a) sr_a <= {sr_a[WORD_W-2:0], sdata_i};
        else      sr_b <= {sr_b[WORD_W-2:0], sdata_i};
      end
    end
  end
endmodule

// File: rtl/srp_port.sv
module srp_port
  import srp_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              sample_req,
  input  logic              chan_en_a,
  input  logic              chan_en_b,
  output logic              bclk_o,
  output logic              fsync_o,
  input  logic              sdata_i,
  output logic [WORD_W-1:0] word_a_data,
  output logic              word_a_valid,
  output logic [WORD_W-1:0] word_b_data,
  output logic              word_b_valid
);
  logic [DIV_W-1:0] div_q;
  port_ctrl_t       ctrl_q;
  logic             run_q, pend_q;
  logic             raw, fall_tick, bit_last;
  logic             cont, take, chan_ok, start_ok;

  assign chan_ok  = chan_en_a || chan_en_b;
  assign start_ok = pend_q && ctrl_q.en && chan_ok;

  srp_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .running(run_q), .div_q(div_q), .ctrl_q(ctrl_q)
  );

  srp_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run_q), .div(div_q),
    .raw_o(raw), .fall_tick_o(fall_tick), .bit_last_o(bit_last)
  );

  srp_frame #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .bit_last(bit_last), .fall_tick(fall_tick),
    .start_ok(start_ok), .sel_a(ctrl_q.sel_a), .sel_b(ctrl_q.sel_b),
    .sdata_i(sdata_i), .fsync_o(fsync_o), .cont_o(cont), .take_o(take),
    .word_a_o(word_a_data), .word_a_valid_o(word_a_valid),
    .word_b_o(word_b_data), .word_b_valid_o(word_b_valid)
  );

  // run starts on enable; stops only at a bit boundary outside a frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (!run_q) run_q <= ctrl_q.en;
      else if (bit_last && !ctrl_q.en && !cont) run_q <= 1'b0;
      if (take) pend_q <= 1'b0;
      if (sample_req && ctrl_q.en && chan_ok) pend_q <= 1'b1;
    end
  end

  assign bclk_o = run_q && (raw ^ ctrl_q.inv);
endmodule

// File: rtl/srp_port_checker.sv
module srp_port_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bclk_o,
  input logic              fsync_o,
  input logic              chan_en_a,
  input logic              chan_en_b,
  input logic              port_en,
  input logic              run,
  input logic              inv,
  input logic [WORD_W-1:0] word_a_data,
  input logic              word_a_valid,
  input logic [WORD_W-1:0] word_b_data,
  input logic              word_b_valid
);
  a_r7_sync_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync_o) |-> $past(port_en && (chan_en_a || chan_en_b)));

  a_r5_low_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> !bclk_o);

  a_r8_inv_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(inv));

  a_r11_a_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_a_valid |=> !word_a_valid);

  a_r11_b_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_b_valid |=> !word_b_valid);

  a_r4_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_a_valid |-> $stable(word_a_data));

  a_r4_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_b_valid |-> $stable(word_b_data));
endmodule

bind srp_port srp_port_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_o(bclk_o), .fsync_o(fsync_o),
  .chan_en_a(chan_en_a), .chan_en_b(chan_en_b), .port_en(ctrl_q.en),
  .run(run_q), .inv(ctrl_q.inv),
  .word_a_data(word_a_data), .word_a_valid(word_a_valid),
  .word_b_data(word_b_data), .word_b_valid(word_b_valid)
);

// File: tb/srp_port_tb_top.sv
`timescale 1ns/1ps
module srp_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_addr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic sample_req = 1'b0, chan_en_a = 1'b1, chan_en_b = 1'b1;
  logic sdata_i = 1'b0;
  logic bclk_o, fsync_o, word_a_valid, word_b_valid;
  logic [15:0] word_a_data, word_b_data;

  always #2.5 clk = ~clk;

  srp_port dut_i (.*);

  int nchk = 0, nerr = 0, cyc = 0;
  int eff_d = 256;
  int got_a = 0, got_b = 0, fs_rises = 0, fs_rise_cyc = 0, fs_prev_rise = 0;
  bit m_sel_a = 0, m_sel_b = 0, inv_m = 0, done_flag = 0;
  logic [15:0] nxt_a = '0, nxt_b = '0, exp_a = '0, exp_b = '0;
  logic [31:0] shreg = '0;
  int remaining = 0;
  logic fs_prev = 1'b0, raw_prev = 1'b0, raw;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_of(input logic [7:0] d);
    return (d == 0) ? 256 : (d == 1) ? 2 : int'(d);
  endfunction

  // monitor and host model, sampled mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (word_a_valid) begin
      got_a++;
      chk(word_a_data == exp_a, "R11 R10 word A", word_a_data, exp_a);
    end
    if (word_b_valid) begin
      got_b++;
      chk(word_b_data == exp_b, "R11 R10 word B", word_b_data, exp_b);
    end
    raw = bclk_o ^ inv_m;
    if (fsync_o && !fs_prev) begin
      fs_prev_rise = fs_rise_cyc;
      fs_rise_cyc = cyc;
      fs_rises++;
      exp_a = nxt_a;
      exp_b = nxt_b;
      if (m_sel_a && m_sel_b) begin shreg = {nxt_a, nxt_b}; remaining = 32; end
      else if (m_sel_a)       begin shreg = {nxt_a, 16'h0}; remaining = 16; end
      else if (m_sel_b)       begin shreg = {nxt_b, 16'h0}; remaining = 16; end
      else remaining = 0;
    end else if (raw && !raw_prev && !fsync_o && remaining > 0) begin
      sdata_i = shreg[31];
      shreg = shreg << 1;
      remaining--;
    end
    if (!fsync_o && fs_prev)
      chk(cyc - fs_rise_cyc == eff_d, "R10 sync width", cyc - fs_rise_cyc, eff_d);
    fs_prev = fsync_o;
    raw_prev = raw;
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!a) eff_d = eff_of(d);
  endtask

  task automatic req();
    @(negedge clk); sample_req = 1'b1;
    @(negedge clk); sample_req = 1'b0;
  endtask

  task automatic stop_port(input logic [7:0] keep);
    wr(1'b1, keep & 8'h0C);
    repeat (eff_d + 4) @(negedge clk);
  endtask

  task automatic measure(input int hi, input int lo, input string tag);
    int h = 0, l = 0;
    logic p;
    p = bclk_o;
    @(negedge clk);
    while (!(bclk_o && !p)) begin p = bclk_o; @(negedge clk); end
    while (bclk_o) begin h++; @(negedge clk); end
    while (!bclk_o) begin l++; @(negedge clk); end
    chk(h == hi, {tag, " high"}, h, hi);
    chk(l == lo, {tag, " low"}, l, lo);
  endtask

  task automatic do_frame(input logic [15:0] a, input logic [15:0] b, input string tag);
    int ga, gb;
    ga = got_a; gb = got_b;
    nxt_a = a; nxt_b = b;
    req();
    repeat (36 * eff_d + 10) @(negedge clk);
    chk(got_a - ga == int'(m_sel_a), {tag, " strobe A count"}, got_a - ga, int'(m_sel_a));
    chk(got_b - gb == int'(m_sel_b), {tag, " strobe B count"}, got_b - gb, int'(m_sel_b));
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done_flag) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int r0, hl;
    logic [7:0] d, c;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    chk(!bclk_o && !fsync_o && !word_a_valid && !word_b_valid, "R3 idle outputs",
        {bclk_o, fsync_o, word_a_valid, word_b_valid}, 0);
    repeat (20) @(negedge clk);
    chk(!bclk_o, "R3 R5 clock held low while disabled", bclk_o, 0);
    // R1 default 256 via enable only
    wr(1'b1, 8'h02);
    measure(128, 128, "R1 zero means 256");
    stop_port(8'h00);
    wr(1'b0, 8'd5); wr(1'b1, 8'h02);
    measure(3, 2, "R2 odd period");
    stop_port(8'h00);
    wr(1'b0, 8'd4); wr(1'b1, 8'h02);
    measure(2, 2, "R2 even period");
    stop_port(8'h00);
    wr(1'b0, 8'd1); wr(1'b1, 8'h02);
    measure(1, 1, "R1 one acts as two");
    stop_port(8'h00);
    hl = 0;
    repeat (30) begin @(negedge clk); if (bclk_o) hl++; end
    chk(hl == 0, "R5 stopped clock stays low", hl, 0);

    // R4 R10 R11 random frames
    for (int i = 0; i < 18; i++) begin
      d = 8'(2 + $urandom_range(0, 7));
      r0 = $urandom_range(1, 3);
      m_sel_a = r0[0]; m_sel_b = r0[1];
      c = {4'h0, m_sel_b, m_sel_a, 2'b10};
      stop_port(c);
      wr(1'b0, d);
      wr(1'b1, c);
      do_frame(16'($urandom), 16'($urandom), "R4 R11 random frame");
    end

    // R7 no channel enabled, then disabled port
    stop_port(8'h0C); m_sel_a = 1; m_sel_b = 1;
    wr(1'b0, 8'd3); wr(1'b1, 8'h0E);
    chan_en_a = 0; chan_en_b = 0;
    r0 = fs_rises;
    req();
    repeat (50) @(negedge clk);
    chan_en_a = 1;
    repeat (150) @(negedge clk);
    chk(fs_rises == r0, "R7 no sync without channel, request dropped", fs_rises - r0, 0);
    stop_port(8'h0C);
    req();
    repeat (150) @(negedge clk);
    chk(fs_rises == r0, "R7 no sync while disabled", fs_rises - r0, 0);
    chan_en_b = 1;

    // R12 back-to-back
    wr(1'b1, 8'h0E);
    nxt_a = 16'hA5C3; nxt_b = 16'h0FF0;
    r0 = got_a;
    req();
    while (fs_rises == 0 || fsync_o == 0) @(negedge clk);
    nxt_a = 16'h8001; nxt_b = 16'h7FFE;
    req();
    repeat (2 * 33 * 3 + 20) @(negedge clk);
    chk(fs_rise_cyc - fs_prev_rise == 99, "R12 sync spacing", fs_rise_cyc - fs_prev_rise, 99);
    chk(got_a - r0 == 2, "R12 two frames delivered", got_a - r0, 2);

    // R6 disable during frame
    stop_port(8'h0C);
    wr(1'b0, 8'd4); wr(1'b1, 8'h0E);
    r0 = got_b;
    nxt_a = 16'h1234; nxt_b = 16'hFEDC;
    req();
    while (!fsync_o) @(negedge clk);
    while (fsync_o) @(negedge clk);
    repeat (20) @(negedge clk);
    wr(1'b1, 8'h0C);
    repeat (35 * 4 + 10) @(negedge clk);
    chk(got_b - r0 == 1, "R6 frame completes after disable", got_b - r0, 1);
    hl = 0;
    repeat (20) begin @(negedge clk); if (bclk_o) hl++; end
    chk(hl == 0, "R6 clock stopped after frame", hl, 0);

    // R8 inversion
    wr(1'b0, 8'd5);
    wr(1'b1, 8'h07); inv_m = 1; m_sel_a = 1; m_sel_b = 0;
    measure(2, 3, "R8 inverted");
    wr(1'b1, 8'h06);
    measure(2, 3, "R8 change while running ignored");
    do_frame(16'hC0DE, 16'h0, "R8 inverted frame");
    stop_port(8'h04);
    wr(1'b1, 8'h06); inv_m = 0;
    measure(3, 2, "R8 taken while stopped");

    // R9 reserved bits
    stop_port(8'h00);
    wr(1'b1, 8'hFA); m_sel_a = 0; m_sel_b = 1;
    measure(3, 2, "R9 no inversion from reserved");
    do_frame(16'h0, 16'hBEEF, "R9 reserved bits ignored");

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule